// File: doc/BRIEF.md
# Two-Channel Split-Phase Pulse Generator

The block drives two pulse outputs. Each output's period is built from two separately programmed tick counts: one sets how long the output stays high and the other how long it then stays low. Ticks come from one of four slow source clocks. Each source is sampled into the system clock domain, and its rising edges are counted. For each channel, the selected edge stream passes through a per-channel divider and then a per-channel gate before it reaches that channel's phase counter.

Software programs the block over a simple word register bus with writes and combinational reads. Each channel has its own duty word. A single control word, shared by both channels, holds each channel's output enable, source select, divide ratio and tick gate. There is no polarity control. To get an inverted waveform, exchange the high and low counts.

Top module: `pwm_pair`

## Requirements
- R1: After reset, every register reads zero and both outputs are low.
- R2: Byte address 0x0 holds channel A's duty word, 0x4 holds channel B's duty word and 0x8 holds the shared control word. Each register reads back the full 32-bit value last written to it. Any other address reads zero.
- R3: In a duty word, bits [15:0] hold the low count L and bits [31:16] hold the high count H. Each period is high for H+1 ticks and then low for L+1 ticks.
- R4: Control word fields. Channel A uses bit 0 for enable, bits [5:4] for source select, bits [14:8] for divide and bit 15 for gate. Channel B uses bit 1 for enable, bits [7:6] for source select, bits [22:16] for divide and bit 23 for gate.
- R5: The source select value S picks source clock S. A source edge is a rising edge of that source after a two-flop synchroniser.
- R6: A divide value N produces one tick for every N+1 edges of the selected source.
- R7: While a channel's gate bit is clear, that channel gets no ticks and its output holds its current level.
- R8: Clearing a channel's enable bit drives its output low in the cycle after the write, even in the middle of a period.
- R9: Setting a channel's enable bit starts a new period at the beginning of the high phase, so the output is high in the cycle after the write.
- R10: A duty word written during a period does not change that period. The new value takes effect from the next period onward.
- R11: A low count of zero still gives exactly one tick of low output in every period.
- R12: The two channels run independently. A channel whose enable bit is clear keeps its output low while the other channel runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 4 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| src_clk | input | 4 | Four slow tick source clocks |
| pwm_out | output | 2 | Pulse outputs, bit 0 channel A, bit 1 channel B |

## Verification
Each source clock runs at a different rate, so every source select value yields a distinct expected length. A wrong mux decode therefore shows up as a wrong high or low length. The bench walks a table of settings that mixes source select values, divide ratios and asymmetric high and low counts on both channels. Asymmetric counts expose swapped duty fields, and a non-zero divide exposes an off-by-one in the divider. Table entries with a zero low count or a zero high count confirm the single-tick minimum phase. Directed sequences cover the remaining cases: a duty rewrite in the middle of a high phase, enable and disable in the middle of a period, and gating off while the output is high.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
  localparam int NUM_CH  = 2;
  localparam int NUM_SRC = 4;
  localparam int SEL_W   = 2;
  localparam int DIV_W   = 7;
  localparam int CNT_W   = 16;

  // Control-word field extraction; positions are fixed by the register map.
  function automatic logic f_en(input logic [31:0] ctrl, input int ch);
    return ctrl[ch];
  endfunction

  function automatic logic [SEL_W-1:0] f_sel(input logic [31:0] ctrl, input int ch);
    return ctrl[4 + 2*ch +: SEL_W];
  endfunction

  function automatic logic [DIV_W-1:0] f_div(input logic [31:0] ctrl, input int ch);
    return ctrl[8 + 8*ch +: DIV_W];
  endfunction

  function automatic logic f_gate(input logic [31:0] ctrl, input int ch);
    return ctrl[15 + 8*ch];
  endfunction
endpackage

// File: rtl/pwm_src_sync.sv
module pwm_src_sync #(
  parameter int NUM_SRC = 4,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_clk,
  output logic [NUM_SRC-1:0] src_rise
);
  logic [NUM_SRC-1:0] stg [STAGES];
  logic [NUM_SRC-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      prev <= '0;
    end else begin
      stg[0] <= src_clk;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      prev <= stg[STAGES-1];
    end
  end

  assign src_rise = stg[STAGES-1] & ~prev;

  // R5: a synchronised rising edge lasts exactly one cycle
  p_rise_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_rise != '0) |=> ((src_rise & $past(src_rise)) == '0));
endmodule

// File: rtl/pwm_tick_div.sv
module pwm_tick_div
  import pwm_pair_pkg::*;
#(
  parameter int NSRC = NUM_SRC,
  parameter int DW   = DIV_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSRC-1:0]          src_rise,
  input  logic [$clog2(NSRC)-1:0]  sel,
  input  logic [DW-1:0]            div,
  input  logic                     gate,
  output logic                     tick
);
  logic          edge_sel;
  logic [DW-1:0] dcnt;
  logic          wrap;

  assign edge_sel = src_rise[sel];
  assign wrap     = (dcnt >= div);
  assign tick     = gate & edge_sel & wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 dcnt <= '0;
    else if (gate && edge_sel)  dcnt <= wrap ? '0 : dcnt + 1'b1;
  end

  // R6: ticks are never on consecutive cycles (edges are spaced)
  p_tick_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  // R6: the edge counter stays within the divide range once it has wrapped
  p_div_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && $stable(div)) |=> (dcnt == '0));
endmodule

// File: rtl/pwm_wave.sv
module pwm_wave
  import pwm_pair_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic [CW-1:0] duty_hi,
  input  logic [CW-1:0] duty_lo,
  output logic          out
);
  logic          phase_hi;
  logic [CW-1:0] cnt, cur_hi, cur_lo;
  logic          end_hi, end_lo;

  assign end_hi = tick & phase_hi & (cnt == cur_hi);
  assign end_lo = tick & ~phase_hi & (cnt == cur_lo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_hi <= 1'b1;
      cnt      <= '0;
      cur_hi   <= '0;
      cur_lo   <= '0;
    end else if (!en) begin
      phase_hi <= 1'b1;
      cnt      <= '0;
      cur_hi   <= duty_hi;
      cur_lo   <= duty_lo;
    end else if (end_hi) begin
      phase_hi <= 1'b0;
      cnt      <= '0;
    end else if (end_lo) begin
      phase_hi <= 1'b1;
      cnt      <= '0;
      cur_hi   <= duty_hi;
      cur_lo   <= duty_lo;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign out = en & phase_hi;

  // R3: the phase counter never passes the active phase length
  p_cnt_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    phase_hi |-> (cnt <= cur_hi));
  p_cnt_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_hi |-> (cnt <= cur_lo));
  // R9: enabling starts in the high phase
  p_start_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> out);
  // R10: a new period uses the duty value present at the boundary
  p_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(phase_hi) && en) |-> (cur_hi == $past(duty_hi)));
endmodule

// File: rtl/pwm_pair.sv
module pwm_pair
  import pwm_pair_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic [3:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_SRC-1:0]  src_clk,
  output logic [NUM_CH-1:0]   pwm_out
);
  localparam logic [3:0] ADDR_CTRL = 4'h8;

  logic [31:0]        duty_q [NUM_CH];
  logic [31:0]        ctrl_q;
  logic [NUM_SRC-1:0] src_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      for (int c = 0; c < NUM_CH; c++) duty_q[c] <= '0;
    end else if (bus_we) begin
      if (bus_addr == ADDR_CTRL) ctrl_q <= bus_wdata;
      for (int c = 0; c < NUM_CH; c++)
        if (bus_addr == 4'(4*c)) duty_q[c] <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_CTRL) bus_rdata = ctrl_q;
    for (int c = 0; c < NUM_CH; c++)
      if (bus_addr == 4'(4*c)) bus_rdata = duty_q[c];
  end

  pwm_src_sync #(.NUM_SRC(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .src_clk(src_clk), .src_rise(src_rise)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic tick;

    pwm_tick_div u_div (
      .clk(clk), .rst_n(rst_n), .src_rise(src_rise),
      .sel(f_sel(ctrl_q, c)), .div(f_div(ctrl_q, c)),
      .gate(f_gate(ctrl_q, c)), .tick(tick)
    );

    pwm_wave u_wave (
      .clk(clk), .rst_n(rst_n), .en(f_en(ctrl_q, c)), .tick(tick),
      .duty_hi(duty_q[c][31:16]), .duty_lo(duty_q[c][15:0]),
      .out(pwm_out[c])
    );

    // R8: clearing the enable bit forces the output low next cycle
    p_disable_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_CTRL && !bus_wdata[c]) |=> !pwm_out[c]);
    // R7: with the gate closed and enable steady the output holds
    p_gate_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!f_gate(ctrl_q, c) && $stable(ctrl_q)) |-> $stable(pwm_out[c]));
    // R2: a duty write is visible in the register next cycle
    p_duty_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == 4'(4*c)) |=> (duty_q[c] == $past(bus_wdata)));
  end
endmodule

// File: tb/pwm_pair_test.sv
module pwm_pair_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  src_clk = '0;
  logic [1:0]  pwm_out;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #4 clk = ~clk;  // 125 MHz

  pwm_pair uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_clk(src_clk), .pwm_out(pwm_out)
  );

  // Source k toggles every k+1 cycles: one rising edge per 2*(k+1) cycles.
  int sdiv [4] = '{0, 0, 0, 0};
  always @(negedge clk) begin
    for (int k = 0; k < 4; k++) begin
      if (sdiv[k] == k) begin
        sdiv[k] = 0;
        src_clk[k] <= ~src_clk[k];
      end else sdiv[k] = sdiv[k] + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles, expected under 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  typedef struct packed {
    logic        ch;
    logic [1:0]  sel;
    logic [6:0]  div;
    logic [15:0] hi;
    logic [15:0] lo;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 7'd0, 16'd3, 16'd5},
    '{1'b0, 2'd1, 7'd0, 16'd2, 16'd2},
    '{1'b0, 2'd2, 7'd1, 16'd1, 16'd0},
    '{1'b0, 2'd3, 7'd2, 16'd0, 16'd1},
    '{1'b1, 2'd0, 7'd3, 16'd4, 16'd2},
    '{1'b1, 2'd1, 7'd0, 16'd0, 16'd0},
    '{1'b1, 2'd3, 7'd0, 16'd7, 16'd0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] mk_ctrl(input int ch, input int sel, input int dv,
                                          input bit gate, input bit en);
    logic [31:0] w = '0;
    if (ch == 0) begin
      w[0] = en; w[5:4] = 2'(sel); w[14:8] = 7'(dv); w[15] = gate;
    end else begin
      w[1] = en; w[7:6] = 2'(sel); w[22:16] = 7'(dv); w[23] = gate;
    end
    return w;
  endfunction

  // Length in system cycles of a phase of n ticks.
  function automatic int phase_cycles(input int n, input int sel, input int dv);
    return (n + 1) * (dv + 1) * 2 * (sel + 1);
  endfunction

  task automatic measure(input int ch, output int hi, output int lo);
    while (pwm_out[ch]) @(negedge clk);
    while (!pwm_out[ch]) @(negedge clk);
    hi = 0;
    while (pwm_out[ch]) begin hi++; @(negedge clk); end
    lo = 0;
    while (!pwm_out[ch]) begin lo++; @(negedge clk); end
  endtask

  initial begin
    logic [31:0] rd;
    int hi, lo, k, held;
    logic lvl;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values
    bus_read(4'h0, rd); check("R1 dutyA", int'(rd), 0);
    bus_read(4'h4, rd); check("R1 dutyB", int'(rd), 0);
    bus_read(4'h8, rd); check("R1 ctrl", int'(rd), 0);
    check("R1 outputs", int'(pwm_out), 0);

    // R2: readback of full words, unmapped address reads zero
    bus_write(4'h0, 32'h1234_5678);
    bus_write(4'h4, 32'h9abc_def0);
    bus_write(4'h8, 32'hff00_00fc);
    bus_read(4'h0, rd); check("R2 dutyA", int'(rd), 32'h1234_5678);
    bus_read(4'h4, rd); check("R2 dutyB", int'(rd), 32'h9abc_def0);
    bus_read(4'h8, rd); check("R2 ctrl", int'(rd), 32'hff00_00fc);
    bus_read(4'hc, rd); check("R2 unmapped", int'(rd), 0);
    bus_write(4'h8, 32'h0);

    // Table walk: R3 R4 R5 R6 R11 R12
    for (int v = 0; v < NV; v++) begin
      int ch = int'(VECS[v].ch);
      int sel = int'(VECS[v].sel);
      int dv = int'(VECS[v].div);
      bus_write(4'h8, 32'h0);
      bus_write(4'(4*ch), {VECS[v].hi, VECS[v].lo});
      bus_write(4'h8, mk_ctrl(ch, sel, dv, 1'b1, 1'b1));
      measure(ch, hi, lo);
      check($sformatf("R3/R4/R5/R6 high v%0d", v), hi, phase_cycles(int'(VECS[v].hi), sel, dv));
      check($sformatf("R3/R11 low v%0d", v), lo, phase_cycles(int'(VECS[v].lo), sel, dv));
      check($sformatf("R12 idle channel v%0d", v), int'(pwm_out[1-ch]), 0);
    end

    // R10: duty rewrite mid high phase applies at next period
    bus_write(4'h8, 32'h0);
    bus_write(4'h0, {16'd9, 16'd3});
    bus_write(4'h8, mk_ctrl(0, 0, 0, 1'b1, 1'b1));
    while (pwm_out[0]) @(negedge clk);
    while (!pwm_out[0]) @(negedge clk);
    hi = 0; k = 0;
    while (pwm_out[0]) begin
      hi++;
      if (k == 3) bus_write(4'h0, {16'd1, 16'd3});
      else @(negedge clk);
      k++;
    end
    lo = 0;
    while (!pwm_out[0]) begin lo++; @(negedge clk); end
    check("R10 current high unchanged", hi, 20);
    check("R10 current low", lo, 8);
    hi = 0;
    while (pwm_out[0]) begin hi++; @(negedge clk); end
    check("R10 next high uses new value", hi, 4);

    // R9: enable starts at high phase; R8: disable forces low at once
    bus_write(4'h8, 32'h0);
    bus_write(4'h0, {16'd9, 16'd9});
    check("R8 low while disabled", int'(pwm_out[0]), 0);
    bus_write(4'h8, mk_ctrl(0, 0, 0, 1'b1, 1'b1));
    check("R9 high right after enable", int'(pwm_out[0]), 1);
    repeat (3) @(negedge clk);
    bus_write(4'h8, mk_ctrl(0, 0, 0, 1'b1, 1'b0));
    check("R8 low right after disable", int'(pwm_out[0]), 0);
    repeat (30) @(negedge clk);
    check("R8 stays low", int'(pwm_out[0]), 0);

    // R7: gate closed while enabled freezes the output
    bus_write(4'h8, mk_ctrl(0, 0, 0, 1'b1, 1'b1));
    repeat (5) @(negedge clk);
    bus_write(4'h8, mk_ctrl(0, 0, 0, 1'b0, 1'b1));
    lvl = pwm_out[0];
    held = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (pwm_out[0] != lvl) held = 0;
    end
    check("R7 output held while gated", held, 1);
    check("R7 held level is high", int'(lvl), 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule